// File: doc/BRIEF.md
# Three-Byte I2C Write Interface for a Double-Buffered Converter

This block is an I2C slave for the digital side of a voltage-output converter. It samples SCL and SDA with a system clock and finds START and STOP conditions. Two ternary select inputs pick one of nine 7-bit addresses. The block also answers a fixed broadcast address, so that one transaction can reach every such device on the bus.

A transaction is an address byte with a write bit, followed by exactly three data bytes. The upper nibble of the first data byte holds a command. The next two bytes hold a 16-bit word, and its top `RES` bits are the converter code. Once the third byte is complete, the command acts on two register stages. It can load the staging (input) register, copy the staging register to the output register, do both, or power the converter down. An update always brings the converter back out of power-down. SDA is open-drain, and the block only ever pulls it low.

Top module: `i2c_dac_wordif`

## Requirements
- R1: After reset, the staging register and the output register are both 0, `pwrdn_o` is 1 and `sda_oe_o` is 0.
- R2: Each select input is encoded as 00 = low, 01 = float, 10 = high, and 11 counts as high. With the select inputs as (sel1, sel0), the address map is:
  - (low, low) = 0010000, (low, float) = 0010001, (low, high) = 0010010
  - (float, low) = 0010011, (float, float) = 0100000, (float, high) = 0100001
  - (high, low) = 0100010, (high, float) = 0100011, (high, high) = 0110000
- R3: The broadcast address 1110011 is acknowledged whatever the select inputs are.
- R4: The address byte is acknowledged (SDA pulled low during the ninth clock) only when the address matches and the R/W bit (bit 0) is 0. After a read request or a wrong address, no later byte is acknowledged and no register changes.
- R5: After an accepted address, the first three data bytes are acknowledged. The fourth and any later byte are not. `sda_oe_o` is never asserted while a data or address bit is on the bus.
- R6: The command is bits 7:4 of the first data byte, and bits 3:0 of that byte are ignored. The second and third bytes form a word sent MSB first, and only its upper `RES` bits (15:4 for 12 bits) are used.
- R7: Command 0000 loads the staging register and leaves the output register and `pwrdn_o` unchanged.
- R8: Command 0001 copies the staging register to the output register and clears `pwrdn_o`.
- R9: Command 0011 loads the staging register and the output register with the new code and clears `pwrdn_o`.
- R10: Command 0100 sets `pwrdn_o` and keeps both registers. Every other command code changes nothing.
- R11: A START or STOP that arrives before the third data byte is complete discards the partial word, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel1_i | input | 2 | First ternary address select |
| addr_sel0_i | input | 2 | Second ternary address select |
| sda_oe_o | output | 1 | When 1, SDA is pulled low (acknowledge) |
| in_code_o | output | RES | Staging register |
| out_code_o | output | RES | Output (converter) register |
| pwrdn_o | output | 1 | Converter power-down flag |

## Verification
SCL and SDA pass through a two-flop synchroniser, then one edge-detect register. The acknowledge output therefore rises three to four system cycles after the SCL falling edge that ends the eighth bit. The bench samples `sda_oe_o` at the middle of the ninth clock's high phase, which comes at least twelve cycles after that edge. The command takes effect about five cycles after the ninth SCL rising edge of the third data byte, once it passes the receive register and the command register. The bench reads the registers only after STOP plus sixteen more cycles, so every result has settled before it is compared.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam logic [6:0] BCAST_ADDR = 7'b1110011;

    localparam logic [3:0] CMD_WRITE   = 4'b0000;
    localparam logic [3:0] CMD_UPDATE  = 4'b0001;
    localparam logic [3:0] CMD_WR_UPD  = 4'b0011;
    localparam logic [3:0] CMD_PWRDN   = 4'b0100;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RX   = 1'b1
    } phase_e;

endpackage

// File: rtl/dacif_bus_sampler.sv
module dacif_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;
    logic scl_s, sda_s;

    assign scl_s = smp_q.scl_sh[SYNC_STAGES-1];
    assign sda_s = smp_q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sh   = {smp_q.scl_sh[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_sh   = {smp_q.sda_sh[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = scl_s;
        smp_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~smp_q.scl_prev;
    assign scl_fall_o = ~scl_s & smp_q.scl_prev;
    assign start_o    = scl_s & smp_q.scl_prev & smp_q.sda_prev & ~sda_s;
    assign stop_o     = scl_s & smp_q.scl_prev & ~smp_q.sda_prev & sda_s;

endmodule

// File: rtl/dacif_addr_map.sv
module dacif_addr_map (
    input  logic [1:0] sel1_i,
    input  logic [1:0] sel0_i,
    output logic [6:0] addr_o
);

    function automatic logic [3:0] tri_level(input logic [1:0] enc);
        case (enc)
            2'b00:   tri_level = 4'd0;
            2'b01:   tri_level = 4'd1;
            default: tri_level = 4'd2;
        endcase
    endfunction

    logic [3:0] slot;

    always_comb begin
        slot = 4'(tri_level(sel1_i) * 4'd3) + tri_level(sel0_i);
        if (slot < 4'd4) begin
            addr_o = 7'b0010000 | {3'b000, slot};
        end else if (slot < 4'd8) begin
            addr_o = 7'b0100000 | {3'b000, slot - 4'd4};
        end else begin
            addr_o = 7'b0110000;
        end
    end

endmodule

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx
    import dacif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sda_s_i,
    input  logic        scl_rise_i,
    input  logic        scl_fall_i,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic [6:0]  own_addr_i,
    output logic        sda_oe_o,
    output logic        exec_o,
    output logic [3:0]  cmd_o,
    output logic [15:0] word_o
);

    typedef struct packed {
        phase_e      phase;
        logic [3:0]  bit_cnt;
        logic [2:0]  byte_idx;
        logic [7:0]  shreg;
        logic        sel;
        logic        ack;
        logic [3:0]  cmd;
        logic [7:0]  hi;
        logic        exec;
        logic [15:0] word;
    } rx_t;

    rx_t rx_d, rx_q;
    logic addr_hit;

    assign addr_hit = ((rx_q.shreg[7:1] == own_addr_i) ||
                       (rx_q.shreg[7:1] == BCAST_ADDR)) && !rx_q.shreg[0];

    always_comb begin
        rx_d      = rx_q;
        rx_d.exec = 1'b0;
        if (start_i) begin
            rx_d.phase    = PH_RX;
            rx_d.bit_cnt  = 4'd0;
            rx_d.byte_idx = 3'd0;
            rx_d.sel      = 1'b0;
            rx_d.ack      = 1'b0;
        end else if (stop_i) begin
            rx_d.phase   = PH_IDLE;
            rx_d.bit_cnt = 4'd0;
            rx_d.ack     = 1'b0;
        end else if (rx_q.phase == PH_RX) begin
            if (scl_rise_i) begin
                if (rx_q.bit_cnt < 4'd8) begin
                    rx_d.shreg   = {rx_q.shreg[6:0], sda_s_i};
                    rx_d.bit_cnt = rx_q.bit_cnt + 4'd1;
                end else if (rx_q.bit_cnt == 4'd8) begin
                    rx_d.bit_cnt = 4'd9;
                    case (rx_q.byte_idx)
                        3'd0: if (!rx_q.sel) rx_d.phase = PH_IDLE;
                        3'd1: rx_d.cmd = rx_q.shreg[7:4];
                        3'd2: rx_d.hi = rx_q.shreg;
                        3'd3: begin
                            rx_d.exec = rx_q.sel;
                            rx_d.word = {rx_q.hi, rx_q.shreg};
                        end
                        default: ;
                    endcase
                    if (rx_q.byte_idx < 3'd4) begin
                        rx_d.byte_idx = rx_q.byte_idx + 3'd1;
                    end
                end
            end else if (scl_fall_i) begin
                if (rx_q.bit_cnt == 4'd8) begin
                    if (rx_q.byte_idx == 3'd0) begin
                        rx_d.sel = addr_hit;
                        rx_d.ack = addr_hit;
                    end else begin
                        rx_d.ack = rx_q.sel && (rx_q.byte_idx <= 3'd3);
                    end
                end else if (rx_q.bit_cnt == 4'd9) begin
                    rx_d.ack     = 1'b0;
                    rx_d.bit_cnt = 4'd0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q       <= '0;
            rx_q.phase <= PH_IDLE;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sda_oe_o = rx_q.ack;
    assign exec_o   = rx_q.exec;
    assign cmd_o    = rx_q.cmd;
    assign word_o   = rx_q.word;

    a_r5_oe_only_in_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.ack |-> (rx_q.bit_cnt == 4'd8 || rx_q.bit_cnt == 4'd9));

    a_r11_exec_after_third_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.exec |-> (rx_q.byte_idx == 3'd4 && rx_q.sel));

    a_r4_unselected_stays_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_q.sel && rx_q.byte_idx != 3'd0) |-> !rx_q.ack);

endmodule

// File: rtl/dacif_cmd_exec.sv
module dacif_cmd_exec
    import dacif_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           exec_i,
    input  logic [3:0]     cmd_i,
    input  logic [15:0]    word_i,
    output logic [RES-1:0] in_code_o,
    output logic [RES-1:0] out_code_o,
    output logic           pwrdn_o
);

    typedef struct packed {
        logic [RES-1:0] in_code;
        logic [RES-1:0] out_code;
        logic           pwrdn;
    } dac_t;

    dac_t dac_d, dac_q;
    logic [RES-1:0] code;

    assign code = word_i[15 -: RES];

    generate
        if (RES < 16) begin : g_low_bits
            logic unused_low;
            assign unused_low = ^word_i[15-RES:0];
        end
    endgenerate

    always_comb begin
        dac_d = dac_q;
        if (exec_i) begin
            case (cmd_i)
                CMD_WRITE: dac_d.in_code = code;
                CMD_UPDATE: begin
                    dac_d.out_code = dac_q.in_code;
                    dac_d.pwrdn    = 1'b0;
                end
                CMD_WR_UPD: begin
                    dac_d.in_code  = code;
                    dac_d.out_code = code;
                    dac_d.pwrdn    = 1'b0;
                end
                CMD_PWRDN: dac_d.pwrdn = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q       <= '0;
            dac_q.pwrdn <= 1'b1;
        end else begin
            dac_q <= dac_d;
        end
    end

    assign in_code_o  = dac_q.in_code;
    assign out_code_o = dac_q.out_code;
    assign pwrdn_o    = dac_q.pwrdn;

    a_r7_write_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == CMD_WRITE) |=> ($stable(dac_q.out_code) && $stable(dac_q.pwrdn)));

    a_r8_update_copies_and_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == CMD_UPDATE) |=> (!dac_q.pwrdn && dac_q.out_code == $past(dac_q.in_code)));

    a_r9_both_stages_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == CMD_WR_UPD) |=> (!dac_q.pwrdn && dac_q.out_code == dac_q.in_code));

    a_r10_pwrdn_holds_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == CMD_PWRDN) |=> (dac_q.pwrdn && $stable(dac_q.in_code) && $stable(dac_q.out_code)));

    a_r11_no_change_without_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(dac_q.in_code) && $stable(dac_q.out_code) && $stable(dac_q.pwrdn)));

endmodule

// File: rtl/i2c_dac_wordif.sv
module i2c_dac_wordif #(
    parameter int RES         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_i,
    input  logic           sda_i,
    input  logic [1:0]     addr_sel1_i,
    input  logic [1:0]     addr_sel0_i,
    output logic           sda_oe_o,
    output logic [RES-1:0] in_code_o,
    output logic [RES-1:0] out_code_o,
    output logic           pwrdn_o
);

    logic        sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [6:0]  own_addr;
    logic        exec;
    logic [3:0]  cmd;
    logic [15:0] word;

    dacif_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    dacif_addr_map u_addr (
        .sel1_i (addr_sel1_i),
        .sel0_i (addr_sel0_i),
        .addr_o (own_addr)
    );

    dacif_frame_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .own_addr_i (own_addr),
        .sda_oe_o   (sda_oe_o),
        .exec_o     (exec),
        .cmd_o      (cmd),
        .word_o     (word)
    );

    dacif_cmd_exec #(.RES(RES)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_i     (exec),
        .cmd_i      (cmd),
        .word_i     (word),
        .in_code_o  (in_code_o),
        .out_code_o (out_code_o),
        .pwrdn_o    (pwrdn_o)
    );

endmodule

// File: tb/i2c_dac_wordif_tb.sv
`timescale 1ns/1ps
module i2c_dac_wordif_tb;

    localparam int RES = 12;
    localparam int Q   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic [1:0] sel1 = 2'b00, sel0 = 2'b00;
    logic sda_oe;
    logic sda_line;
    logic [RES-1:0] in_code, out_code;
    logic pwrdn;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [RES-1:0] m_in = '0, m_out = '0;
    logic m_pd = 1'b1;

    always #4 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2c_dac_wordif #(.RES(RES)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .addr_sel1_i (sel1),
        .addr_sel0_i (sel0),
        .sda_oe_o    (sda_oe),
        .in_code_o   (in_code),
        .out_code_o  (out_code),
        .pwrdn_o     (pwrdn)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_addr(input int a, input int b);
        int idx = 3 * a + b;
        if (idx < 4) return 7'b0010000 + 7'(idx);
        if (idx < 8) return 7'b0100000 + 7'(idx - 4);
        return 7'b0110000;
    endfunction

    task automatic bus_start();
        sda_drv = 1'b1; wait_cyc(Q);
        scl = 1'b1;     wait_cyc(Q);
        sda_drv = 1'b0; wait_cyc(Q);
        scl = 1'b0;     wait_cyc(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_cyc(Q);
        scl = 1'b1;     wait_cyc(Q);
        sda_drv = 1'b1; wait_cyc(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic oe_bad = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_cyc(Q);
            scl = 1'b1;     wait_cyc(Q / 2);
            if (sda_oe) oe_bad = 1'b1;
            wait_cyc(Q / 2);
            scl = 1'b0;     wait_cyc(Q);
        end
        check(!oe_bad, "R5 oe quiet during bits", 32'(oe_bad), 0);
        sda_drv = 1'b1; wait_cyc(Q);
        scl = 1'b1;     wait_cyc(Q / 2);
        acked = sda_oe;
        wait_cyc(Q / 2);
        scl = 1'b0;     wait_cyc(Q);
    endtask

    task automatic xact(input logic [6:0] addr, input logic rw, input int n,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3, input logic [7:0] b4, output logic [5:0] acks);
        logic [7:0] bytes [5];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3; bytes[4] = b4;
        acks = '0;
        bus_start();
        send_byte({addr, rw}, acks[0]);
        for (int i = 0; i < n; i++) send_byte(bytes[i], acks[i + 1]);
        bus_stop();
        wait_cyc(2 * Q);
    endtask

    task automatic model_exec(input logic [3:0] c, input logic [15:0] w);
        case (c)
            4'b0000: m_in = w[15 -: RES];
            4'b0001: begin m_out = m_in; m_pd = 1'b0; end
            4'b0011: begin m_in = w[15 -: RES]; m_out = w[15 -: RES]; m_pd = 1'b0; end
            4'b0100: m_pd = 1'b1;
            default: ;
        endcase
    endtask

    task automatic check_regs(input string req);
        check(in_code == m_in, req, 32'(in_code), 32'(m_in));
        check(out_code == m_out, req, 32'(out_code), 32'(m_out));
        check(pwrdn == m_pd, req, 32'(pwrdn), 32'(m_pd));
    endtask

    task automatic t_reset();
        check(in_code == '0, "R1 in", 32'(in_code), 0);
        check(out_code == '0, "R1 out", 32'(out_code), 0);
        check(pwrdn == 1'b1, "R1 pwrdn", 32'(pwrdn), 1);
        check(sda_oe == 1'b0, "R1 oe", 32'(sda_oe), 0);
    endtask

    task automatic t_addr_map();
        logic [5:0] acks;
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                logic [15:0] w = 16'(((a * 3 + b) * 16'h1230) | 16'h0005);
                sel1 = 2'(a); sel0 = 2'(b);
                xact(exp_addr(a, b), 1'b0, 3, 8'h30, w[15:8], w[7:0], 8'h00, 8'h00, acks);
                model_exec(4'b0011, w);
                check(acks[3:0] == 4'b1111, "R2 own address acked", 32'(acks), 32'hF);
                check_regs("R2 map write");
                xact(exp_addr((a + 1) % 3, b), 1'b0, 3, 8'h30, 8'hFF, 8'hF0, 8'h00, 8'h00, acks);
                check(acks == 6'b0, "R4 wrong address no ack", 32'(acks), 0);
                check_regs("R4 wrong address no effect");
            end
        end
        sel1 = 2'b11; sel0 = 2'b00;
        xact(7'b0100010, 1'b0, 3, 8'h30, 8'h7E, 8'h50, 8'h00, 8'h00, acks);
        model_exec(4'b0011, 16'h7E50);
        check(acks[3:0] == 4'b1111, "R2 code 11 as high", 32'(acks), 32'hF);
        check_regs("R2 code 11 as high");
    endtask

    task automatic t_global();
        logic [5:0] acks;
        sel1 = 2'b01; sel0 = 2'b10;
        xact(7'b1110011, 1'b0, 3, 8'h00, 8'h45, 8'h60, 8'h00, 8'h00, acks);
        model_exec(4'b0000, 16'h4560);
        check(acks[3:0] == 4'b1111, "R3 broadcast acked", 32'(acks), 32'hF);
        check_regs("R3 broadcast write");
    endtask

    task automatic t_read();
        logic [5:0] acks;
        sel1 = 2'b00; sel0 = 2'b00;
        xact(7'b0010000, 1'b1, 3, 8'h30, 8'hAA, 8'hA0, 8'h00, 8'h00, acks);
        check(acks == 6'b0, "R4 read not acked", 32'(acks), 0);
        check_regs("R4 read no effect");
    endtask

    task automatic t_commands();
        logic [5:0] acks;
        sel1 = 2'b10; sel0 = 2'b10;
        xact(7'b0110000, 1'b0, 3, 8'h00, 8'h9A, 8'hB0, 8'h00, 8'h00, acks);
        model_exec(4'b0000, 16'h9AB0);
        check_regs("R7 write only");
        xact(7'b0110000, 1'b0, 3, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, acks);
        model_exec(4'b0100, 16'h0000);
        check_regs("R10 power down");
        xact(7'b0110000, 1'b0, 3, 8'h10, 8'h11, 8'h10, 8'h00, 8'h00, acks);
        model_exec(4'b0001, 16'h1110);
        check_regs("R8 update wakes");
        xact(7'b0110000, 1'b0, 3, 8'h70, 8'h22, 8'h20, 8'h00, 8'h00, acks);
        check_regs("R10 unknown code ignored");
        xact(7'b0110000, 1'b0, 3, 8'h3A, 8'hAB, 8'hCF, 8'h00, 8'h00, acks);
        model_exec(4'b0011, 16'hABCF);
        check(out_code == 12'hABC, "R6 low nibble and low bits ignored", 32'(out_code), 32'hABC);
        check_regs("R9 write and update");
    endtask

    task automatic t_extra_bytes();
        logic [5:0] acks;
        xact(7'b0110000, 1'b0, 5, 8'h30, 8'h5D, 8'hE0, 8'h12, 8'h34, acks);
        model_exec(4'b0011, 16'h5DE0);
        check(acks == 6'b001111, "R5 fourth and fifth byte refused", 32'(acks), 32'h0F);
        check_regs("R5 extra bytes ignored");
    endtask

    task automatic t_abort();
        logic a0, a1, a2;
        logic [5:0] acks;
        bus_start();
        send_byte({7'b0110000, 1'b0}, a0);
        send_byte(8'h30, a1);
        send_byte(8'hF0, a2);
        bus_stop();
        wait_cyc(2 * Q);
        check_regs("R11 stop mid word");
        bus_start();
        send_byte({7'b0110000, 1'b0}, a0);
        send_byte(8'h00, a1);
        send_byte(8'hE1, a2);
        xact(7'b0110000, 1'b0, 3, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, acks);
        model_exec(4'b0001, 16'h0000);
        check(acks[3:0] == 4'b1111, "R11 restart accepted", 32'(acks), 32'hF);
        check_regs("R11 repeated start discards partial");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_addr_map();
        t_global();
        t_read();
        t_commands();
        t_extra_bytes();
        t_abort();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule